// File: doc/BRIEF.md
# Auto-Reloading Down-Counter Timer

This block is a down-counter of configurable width (32 bits by default). It steps down by one on every cycle in which the tick-enable input is high, so it runs at the time-base rate. When a step takes the count from one to zero, the block raises a sticky status flag. If the interrupt enable is set, that flag drives the interrupt output.

Software programs the block through a single synchronous write port. A two-bit selector picks what the write updates: the count, the reload value, the control bits, or the status flag, which is write-one-to-clear. With auto-reload switched on and a nonzero reload value, the count restarts from the reload value when it expires. In every other case the count rests at zero until software writes a new value.

Top module: `decr_reload_unit`

## Requirements
- R1: After reset the count is 0, the status flag is 0, the interrupt output is 0, and the interrupt-enable, auto-reload and reload value are all cleared.
- R2: With a nonzero count and no count write, a cycle with `tick` high lowers the count by exactly one, and a cycle with `tick` low leaves it unchanged.
- R3: A tick that takes the count from 1 to 0 sets the status flag at the same clock edge, and the flag stays set until software clears it.
- R4: When auto-reload is on (control bit 22 = 1) and the reload value is nonzero, the expiring tick loads the reload value into the count instead of zero.
- R5: When auto-reload is on but the reload value is zero, the expiring tick leaves the count at 0, and further ticks cause no new expiry.
- R6: With auto-reload off, the count holds at 0 after expiry, and ticks at zero never set the status flag again.
- R7: `irq` is high exactly when the status flag is set and the interrupt enable (control bit 26) is 1.
- R8: A status write (`wr_sel` = 3) clears the flag only when data bit 27 is 1. A status write with bit 27 at 0 has no effect.
- R9: If an expiry and a status clear happen in the same cycle, the flag ends up set.
- R10: A count write (`wr_sel` = 0) loads `wr_data` and takes priority over a tick in the same cycle.
- R11: Writing 0 to the count does not set the status flag.

Write selector encoding: 0 = count, 1 = reload value, 2 = control (bit 26 interrupt enable, bit 22 auto-reload, all other bits ignored), 3 = status (bit 27 clears the flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 reload, 2 control, 3 status |
| wr_data | input | 32 | Write data |
| tick | input | 1 | Time-base tick enable |
| dec_value | output | 32 | Current count |
| dec_status | output | 1 | Sticky expiry flag |
| irq | output | 1 | Interrupt request |

## Verification
The count can be off by one step, reload from the wrong source, or fail to stop at zero. Each of these shows on `dec_value` in the first cycle after the faulty edge, and a reference model compares that output on every clock. A lost or spurious expiry shows on `dec_status` at the same edge as the step from 1 to 0. A wrong enable shows on `irq` without delay. The same-cycle clash between clear and expiry is driven directly, because otherwise it would only be reached by chance.

// File: rtl/decr_pkg.sv
// Package: shared write-selector encoding for the decrementer block.
// Assumes a two-bit selector on the register write port.
package decr_pkg;
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_STATUS = 2'd3
    } wsel_e;
endpackage

// File: rtl/decr_regs.sv
// Module: holds the reload value and the two control bits.
// Assumes write strobes are already decoded by the top; other control bits are dropped.
module decr_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_reload,
    input  logic         ld_ctrl,
    input  logic [W-1:0] data,
    input  logic         die_in,
    input  logic         are_in,
    output logic [W-1:0] reload_val,
    output logic         die,
    output logic         are
);
    // Reload register: loaded by a reload-select write.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_val <= '0;
        else if (ld_reload) reload_val <= data;
    end

    // Control bits: replaced as a whole by a control-select write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            die <= 1'b0;
            are <= 1'b0;
        end else if (ld_ctrl) begin
            die <= die_in;
            are <= are_in;
        end
    end
endmodule

// File: rtl/decr_counter.sv
// Module: the down-counter with zero-triggered expiry and guarded reload.
// Assumes a software load beats a tick; a count at zero neither moves nor expires.
module decr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         tick,
    input  logic         are,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] value,
    output logic         expire
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic at_one;
    logic at_zero;
    logic do_reload;

    // Decode of the current count and of the reload condition.
    always_comb begin
        at_one    = (value == ONE);
        at_zero   = (value == ZERO);
        do_reload = are && (reload_val != ZERO);
        expire    = tick && !ld && at_one;
    end

    // Count register: load, step, or expire with optional reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= ZERO;
        end else if (ld) begin
            value <= ld_val;
        end else if (tick && !at_zero) begin
            if (at_one) value <= do_reload ? reload_val : ZERO;
            else        value <= value - ONE;
        end
    end
endmodule

// File: rtl/decr_flag.sv
// Module: sticky expiry flag with write-one-to-clear and the gated interrupt.
// Assumes an expiry in the same cycle as a clear leaves the flag set.
module decr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    input  logic die,
    output logic status,
    output logic irq
);
    // Flag register: set on expiry, cleared on request, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      status <= 1'b0;
        else if (expire) status <= 1'b1;
        else if (clr)    status <= 1'b0;
    end

    // Interrupt request: flag gated by the enable.
    always_comb irq = status && die;
endmodule

// File: rtl/decr_reload_unit.sv
// Module: top of the decrementer; decodes the write port and wires the parts.
// Assumes synchronous writes, one target per cycle, and a single-cycle tick enable.
module decr_reload_unit #(
    parameter int W       = 32,
    parameter int DIE_BIT = 26,
    parameter int ARE_BIT = 22,
    parameter int DIS_BIT = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         tick,
    output logic [W-1:0] dec_value,
    output logic         dec_status,
    output logic         irq
);
    import decr_pkg::*;

    wsel_e        sel;
    logic         ld_count, ld_reload, ld_ctrl, clr_req;
    logic [W-1:0] reload_val;
    logic         die, are, expire;

    // Write decode: one strobe per target.
    always_comb begin
        sel       = wsel_e'(wr_sel);
        ld_count  = wr_en && (sel == SEL_COUNT);
        ld_reload = wr_en && (sel == SEL_RELOAD);
        ld_ctrl   = wr_en && (sel == SEL_CTRL);
        clr_req   = wr_en && (sel == SEL_STATUS) && wr_data[DIS_BIT];
    end

    decr_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ld_reload(ld_reload), .ld_ctrl(ld_ctrl), .data(wr_data),
        .die_in(wr_data[DIE_BIT]), .are_in(wr_data[ARE_BIT]),
        .reload_val(reload_val), .die(die), .are(are)
    );

    decr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .ld(ld_count), .ld_val(wr_data), .tick(tick),
        .are(are), .reload_val(reload_val),
        .value(dec_value), .expire(expire)
    );

    decr_flag u_flag (
        .clk(clk), .rst_n(rst_n),
        .expire(expire), .clr(clr_req), .die(die),
        .status(dec_status), .irq(irq)
    );
endmodule

// File: rtl/decr_reload_chk.sv
// Module: port-level checker for the decrementer, attached by bind.
// Assumes the default selector encoding and status bit position.
module decr_reload_chk #(
    parameter int W       = 32,
    parameter int DIS_BIT = 27
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   wr_sel,
    input logic [W-1:0] wr_data,
    input logic         tick,
    input logic [W-1:0] dec_value,
    input logic         dec_status,
    input logic         irq
);
    logic cnt_wr, st_clr;
    always_comb begin
        cnt_wr = wr_en && (wr_sel == 2'd0);
        st_clr = wr_en && (wr_sel == 2'd3) && wr_data[DIS_BIT];
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && tick && dec_value > W'(1)) |=> dec_value == $past(dec_value) - W'(1));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !tick) |=> $stable(dec_value));
    p_expiry_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && tick && dec_value == W'(1)) |=> dec_status);
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_status && !st_clr) |=> dec_status);
    p_zero_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_value == '0 && !cnt_wr) |=> dec_value == '0);
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> dec_status);
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> dec_value == $past(wr_data));
endmodule

bind decr_reload_unit decr_reload_chk #(.W(W), .DIS_BIT(DIS_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .dec_value(dec_value), .dec_status(dec_status), .irq(irq)
);

// File: tb/sim_decr_reload_unit.sv
`timescale 1ns/1ps
module sim_decr_reload_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [31:0] dec_value;
    logic        dec_status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    decr_reload_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tick(tick),
        .dec_value(dec_value), .dec_status(dec_status), .irq(irq)
    );

    // Behavioural reference state.
    longint m_cnt = 0, m_rel = 0;
    bit m_st = 0, m_die = 0, m_are = 0;

    always @(posedge clk) begin
        bit ex;
        ex = 0;
        if (!rst_n) begin
            m_cnt <= 0; m_rel <= 0; m_st <= 0; m_die <= 0; m_are <= 0;
        end else begin
            if (wr_en && wr_sel == 0) m_cnt <= wr_data;
            else if (tick && m_cnt > 0) begin
                if (m_cnt == 1) begin
                    ex = 1;
                    m_cnt <= (m_are && m_rel != 0) ? m_rel : 0;
                end else m_cnt <= m_cnt - 1;
            end
            if (ex) m_st <= 1;
            else if (wr_en && wr_sel == 3 && wr_data[27]) m_st <= 0;
            if (wr_en && wr_sel == 1) m_rel <= wr_data;
            if (wr_en && wr_sel == 2) begin
                m_die <= wr_data[26];
                m_are <= wr_data[22];
            end
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model count", dec_value, m_cnt);
            chk("R3 model status", dec_status, m_st);
            chk("R7 model irq", irq, m_st && m_die);
        end
    end

    task automatic cyc(bit en, logic [1:0] s, logic [31:0] d, bit tk);
        wr_en = en; wr_sel = s; wr_data = d; tick = tk;
        @(negedge clk);
        wr_en = 0; tick = 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 1);
    endtask

    localparam logic [31:0] CLR = 32'h0800_0000;
    localparam logic [31:0] DIE = 32'h0400_0000;
    localparam logic [31:0] ARE = 32'h0040_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 count after reset", dec_value, 0);
        chk("R1 status after reset", dec_status, 0);
        chk("R1 irq after reset", irq, 0);

        cyc(1, 0, 5, 0);
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        chk("R2 hold without tick", dec_value, 5);
        ticks(3);
        chk("R2 three steps", dec_value, 2);

        ticks(2);
        chk("R3 expiry sets flag", dec_status, 1);
        chk("R7 irq low without enable", irq, 0);
        cyc(1, 2, DIE, 0);
        chk("R7 irq with enable", irq, 1);

        cyc(1, 3, ~CLR, 0);
        chk("R8 clear without bit 27 ignored", dec_status, 1);
        cyc(1, 3, CLR, 0);
        chk("R8 clear with bit 27", dec_status, 0);
        chk("R7 irq drops with flag", irq, 0);
        ticks(5);
        chk("R6 count rests at zero", dec_value, 0);
        chk("R6 no new expiry at zero", dec_status, 0);

        cyc(1, 0, 0, 1);
        ticks(3);
        chk("R11 zero write no expiry", dec_status, 0);

        cyc(1, 1, 3, 0);
        cyc(1, 2, ARE | DIE, 0);
        cyc(1, 0, 2, 0);
        ticks(2);
        chk("R4 reload on expiry", dec_value, 3);
        chk("R4 flag set", dec_status, 1);
        cyc(1, 3, CLR, 0);
        ticks(12);
        chk("R4 periodic reload count", dec_value, 3);

        cyc(1, 1, 0, 0);
        cyc(1, 3, CLR, 0);
        cyc(1, 0, 1, 0);
        ticks(1);
        chk("R5 zero reload rests", dec_value, 0);
        chk("R5 flag set", dec_status, 1);
        cyc(1, 3, CLR, 0);
        ticks(4);
        chk("R5 no retrigger", dec_status, 0);

        cyc(1, 2, 0, 0);
        cyc(1, 0, 1, 0);
        cyc(1, 3, CLR, 1);
        chk("R9 expiry beats clear", dec_status, 1);

        cyc(1, 0, 10, 1);
        chk("R10 write beats tick", dec_value, 10);
        cyc(1, 0, 32'hFFFF_FFFF, 0);
        ticks(2);
        chk("R2 steps from full scale", dec_value, 32'hFFFF_FFFD);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule